// File: doc/BRIEF.md
# Two-Channel Break Event Arbiter

This block is the decision stage that follows the two comparator channels of a debug break unit. In every clock cycle each channel may report a match. The report gives the kind of break (before execution, after execution, or on an operand access), the address of the matched instruction and the address of the instruction after it. The same cycle also carries any processor exception that occurs together with the match, classed as re-execution type or completion type. From these inputs the block decides two things separately: whether a break request goes out, and which channel match flags are recorded.

A break request is a registered single-cycle pulse. It comes with the saved program counter to report and a mask of the channel or channels it stands for. After a request the block stays pending, and issues no new request, until the consumer acknowledges. The two match flags are sticky. Software clears them by writing ones. A channel that matches in a cycle where no exception suppresses it sets its flag, even when its break is not the one issued. All outputs are registered and change one clock after the inputs that cause them.

Top module: `brk_event_arbiter`

## Requirements
- R1: The saved PC of a before-execution match (kind 0) is the channel's instruction address. The saved PC of an after-execution match (kind 1) or an operand match (kind 2) is the channel's next-instruction address.
- R2: When an exception of re-execution type is present (exc_valid=1, exc_reexec=1), no break request is issued and neither match flag is set in that cycle. This also covers the multi-cycle instruction conflict.
- R3: When an exception of completion type is present (exc_valid=1, exc_reexec=0), kind 1 and kind 2 matches issue no request but still set their channel's flag. A kind 0 match still issues its break and sets its flag.
- R4: When both channels yield a break with the same saved PC, exactly one request is issued, with brk_src=2'b11, and both flags are set.
- R5: When both channels yield breaks with different saved PCs, the lower saved PC is issued, with brk_src one-hot for the winner (bit 0 = channel 0). Both flags are set.
- R6: A match with kind 3 is ignored. It raises no request and sets no flag.
- R7: match_flags bit n is set by a channel n match and stays set until a cycle with flag_clr=1 and flag_clr_mask bit n = 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R8: brk_req is high for one cycle. brk_pending rises with it and stays high until the cycle after brk_ack. Breaks that arrive while the block is pending are dropped, but their flags are still set.
- R9: A synchronous active-high reset clears brk_req, brk_pending and match_flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch0_hit | input | 1 | Channel 0 match this cycle |
| ch0_kind | input | 2 | Channel 0 break kind (0 before, 1 after, 2 operand, 3 reserved) |
| ch0_pc | input | AW | Channel 0 matched instruction address |
| ch0_next_pc | input | AW | Channel 0 following instruction address |
| ch1_hit | input | 1 | Channel 1 match this cycle |
| ch1_kind | input | 2 | Channel 1 break kind |
| ch1_pc | input | AW | Channel 1 matched instruction address |
| ch1_next_pc | input | AW | Channel 1 following instruction address |
| exc_valid | input | 1 | Coincident exception present |
| exc_reexec | input | 1 | Exception class: 1 re-execution, 0 completion |
| flag_clr | input | 1 | Software clear strobe for the flags |
| flag_clr_mask | input | 2 | Write-one-to-clear mask for the flags |
| brk_ack | input | 1 | Acknowledge of the pending request |
| brk_req | output | 1 | Break request pulse |
| brk_spc | output | AW | Saved PC for the request |
| brk_src | output | 2 | Channels represented by the request |
| brk_pending | output | 1 | Request outstanding, awaiting acknowledge |
| match_flags | output | 2 | Sticky channel match flags |

## Verification
The assertions assume that brk_ack only arrives while a request is pending, and that the clear strobe and the exception inputs are free of X after reset. The bench follows these rules. It raises brk_ack only when its model shows a pending request, and it drives every input to a known value in every cycle. Random cycles draw addresses from a small even-valued pool so that equal and unequal saved PCs both occur often. Reserved kinds, both exception classes, and clears that collide with sets are all mixed in.

// File: rtl/brk_event_arbiter.sv
module brk_event_arbiter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ch0_hit,
  input  logic [1:0]    ch0_kind,
  input  logic [AW-1:0] ch0_pc,
  input  logic [AW-1:0] ch0_next_pc,
  input  logic          ch1_hit,
  input  logic [1:0]    ch1_kind,
  input  logic [AW-1:0] ch1_pc,
  input  logic [AW-1:0] ch1_next_pc,
  input  logic          exc_valid,
  input  logic          exc_reexec,
  input  logic          flag_clr,
  input  logic [1:0]    flag_clr_mask,
  input  logic          brk_ack,
  output logic          brk_req,
  output logic [AW-1:0] brk_spc,
  output logic [1:0]    brk_src,
  output logic          brk_pending,
  output logic [1:0]    match_flags
);
  localparam logic [1:0] KIND_PRE = 2'd0;
  localparam logic [1:0] KIND_RSV = 2'd3;

  logic exc_re, exc_cp;
  assign exc_re = exc_valid && exc_reexec;
  assign exc_cp = exc_valid && !exc_reexec;

  logic c0_set, c1_set, c0_brk, c1_brk;
  logic [AW-1:0] c0_spc, c1_spc;

  assign c0_set = ch0_hit && (ch0_kind != KIND_RSV) && !exc_re;
  assign c1_set = ch1_hit && (ch1_kind != KIND_RSV) && !exc_re;
  assign c0_brk = c0_set && !(exc_cp && ch0_kind != KIND_PRE);
  assign c1_brk = c1_set && !(exc_cp && ch1_kind != KIND_PRE);
  assign c0_spc = (ch0_kind == KIND_PRE) ? ch0_pc : ch0_next_pc;
  assign c1_spc = (ch1_kind == KIND_PRE) ? ch1_pc : ch1_next_pc;

  logic pick0, pick1, issue;
  assign pick0 = c0_brk && (!c1_brk || c0_spc <= c1_spc);
  assign pick1 = c1_brk && (!c0_brk || c1_spc <= c0_spc);
  assign issue = (c0_brk || c1_brk) && !brk_pending;

  logic [1:0] clr_bits;
  assign clr_bits = flag_clr ? flag_clr_mask : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req     <= 1'b0;
      brk_pending <= 1'b0;
      brk_spc     <= '0;
      brk_src     <= 2'b00;
      match_flags <= 2'b00;
    end else begin
      brk_req     <= issue;
      brk_pending <= issue || (brk_pending && !brk_ack);
      if (issue) begin
        brk_spc <= pick0 ? c0_spc : c1_spc;
        brk_src <= {pick1, pick0};
      end
      match_flags <= (match_flags & ~clr_bits) | {c1_set, c0_set};
    end
  end

  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req);
  assert_hold_while_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (brk_pending && !brk_ack) |=> !brk_req);
  assert_src_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> brk_src != 2'b00);
  assert_reexec_no_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_reexec && !flag_clr) |=> match_flags == $past(match_flags));
  assert_reexec_no_req_R2: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_reexec) |=> !brk_req);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !flag_clr |=> (match_flags & $past(match_flags)) == $past(match_flags));
  assert_pending_with_req_R8: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> brk_pending);
endmodule

// File: tb/brk_event_arbiter_bench.sv
module brk_event_arbiter_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic ch0_hit = 0, ch1_hit = 0;
  logic [1:0] ch0_kind = 0, ch1_kind = 0;
  logic [31:0] ch0_pc = 0, ch0_next_pc = 0, ch1_pc = 0, ch1_next_pc = 0;
  logic exc_valid = 0, exc_reexec = 0, flag_clr = 0, brk_ack = 0;
  logic [1:0] flag_clr_mask = 0;
  logic brk_req, brk_pending;
  logic [31:0] brk_spc;
  logic [1:0] brk_src, match_flags;

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_mf = 0;
  logic m_pend = 0;

  always #10 clk = ~clk;

  brk_event_arbiter u_brk_event_arbiter (
    .clk(clk), .rst(rst),
    .ch0_hit(ch0_hit), .ch0_kind(ch0_kind), .ch0_pc(ch0_pc), .ch0_next_pc(ch0_next_pc),
    .ch1_hit(ch1_hit), .ch1_kind(ch1_kind), .ch1_pc(ch1_pc), .ch1_next_pc(ch1_next_pc),
    .exc_valid(exc_valid), .exc_reexec(exc_reexec),
    .flag_clr(flag_clr), .flag_clr_mask(flag_clr_mask), .brk_ack(brk_ack),
    .brk_req(brk_req), .brk_spc(brk_spc), .brk_src(brk_src),
    .brk_pending(brk_pending), .match_flags(match_flags));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] saved_pc(logic [1:0] k, logic [31:0] p, logic [31:0] n);
    return (k == 2'd0) ? p : n;
  endfunction

  function automatic logic fires(logic h, logic [1:0] k, logic ev, logic re);
    if (!h || k == 2'd3 || (ev && re)) return 1'b0;
    if (ev && !re && k != 2'd0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic marks(logic h, logic [1:0] k, logic ev, logic re);
    return h && k != 2'd3 && !(ev && re);
  endfunction

  task automatic cyc(string tag);
    logic b0, b1, e_req;
    logic [31:0] s0, s1, e_spc;
    logic [1:0] e_src, clr;
    b0 = fires(ch0_hit, ch0_kind, exc_valid, exc_reexec);
    b1 = fires(ch1_hit, ch1_kind, exc_valid, exc_reexec);
    s0 = saved_pc(ch0_kind, ch0_pc, ch0_next_pc);
    s1 = saved_pc(ch1_kind, ch1_pc, ch1_next_pc);
    e_req = (b0 || b1) && !m_pend;
    if (b0 && b1) begin
      e_spc = (s0 < s1) ? s0 : s1;
      e_src = (s0 == s1) ? 2'b11 : ((s0 < s1) ? 2'b01 : 2'b10);
    end else begin
      e_spc = b0 ? s0 : s1;
      e_src = b0 ? 2'b01 : 2'b10;
    end
    clr = flag_clr ? flag_clr_mask : 2'b00;
    m_mf = (m_mf & ~clr) | {marks(ch1_hit, ch1_kind, exc_valid, exc_reexec),
                            marks(ch0_hit, ch0_kind, exc_valid, exc_reexec)};
    m_pend = e_req || (m_pend && !brk_ack);
    @(posedge clk);
    #1;
    chk({tag, " R8 req"}, brk_req, e_req);
    chk({tag, " R8 pending"}, brk_pending, m_pend);
    chk({tag, " R7 flags"}, match_flags, m_mf);
    if (e_req) begin
      chk({tag, " R1 spc"}, brk_spc, e_spc);
      chk({tag, " R5 src"}, brk_src, e_src);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    ch0_hit = 0; ch1_hit = 0; exc_valid = 0; exc_reexec = 0;
    flag_clr = 0; flag_clr_mask = 0; brk_ack = 0;
  endtask

  task automatic set0(logic [1:0] k, logic [31:0] p);
    ch0_hit = 1; ch0_kind = k; ch0_pc = p; ch0_next_pc = p + 2;
  endtask

  task automatic set1(logic [1:0] k, logic [31:0] p);
    ch1_hit = 1; ch1_kind = k; ch1_pc = p; ch1_next_pc = p + 2;
  endtask

  task automatic ack_it();
    idle(); brk_ack = m_pend; cyc("ack"); idle();
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R9 reset req", brk_req, 0);
    chk("R9 reset pending", brk_pending, 0);
    chk("R9 reset flags", match_flags, 0);

    idle(); set0(2'd1, 32'h110); set1(2'd0, 32'h112); cyc("R4 equal spc"); ack_it();
    idle(); flag_clr = 1; flag_clr_mask = 2'b11; cyc("R7 clear");
    idle(); set0(2'd1, 32'h200); exc_valid = 1; exc_reexec = 1; cyc("R2 reexec post");
    idle(); set1(2'd0, 32'h204); exc_valid = 1; exc_reexec = 1; cyc("R2 reexec pre");
    idle(); set0(2'd2, 32'h300); exc_valid = 1; cyc("R3 trap operand");
    idle(); set1(2'd0, 32'h310); exc_valid = 1; cyc("R3 trap pre"); ack_it();
    idle(); flag_clr = 1; flag_clr_mask = 2'b11; cyc("R7 clear2");
    idle(); set0(2'd0, 32'h420); set1(2'd1, 32'h400); cyc("R5 lower wins"); ack_it();
    idle(); flag_clr = 1; flag_clr_mask = 2'b11; cyc("R7 clear3");
    idle(); set0(2'd3, 32'h500); set1(2'd3, 32'h500); cyc("R6 reserved");
    idle(); set0(2'd1, 32'h600); cyc("R1 post");
    idle(); set1(2'd0, 32'h700); cyc("R8 dropped while pending");
    idle(); cyc("R8 still pending"); ack_it();
    idle(); set0(2'd0, 32'h800); flag_clr = 1; flag_clr_mask = 2'b11; cyc("R7 set beats clear"); ack_it();

    for (int i = 0; i < 3000; i++) begin
      idle();
      ch0_hit = ($urandom_range(0, 2) != 0);
      ch1_hit = ($urandom_range(0, 2) != 0);
      ch0_kind = 2'($urandom_range(0, 3));
      ch1_kind = 2'($urandom_range(0, 3));
      ch0_pc = 32'h100 + 2 * $urandom_range(0, 5); ch0_next_pc = ch0_pc + 2;
      ch1_pc = 32'h100 + 2 * $urandom_range(0, 5); ch1_next_pc = ch1_pc + 2;
      exc_valid = ($urandom_range(0, 5) == 0);
      exc_reexec = 1'($urandom_range(0, 1));
      flag_clr = ($urandom_range(0, 3) == 0);
      flag_clr_mask = 2'($urandom_range(0, 3));
      brk_ack = m_pend && ($urandom_range(0, 2) == 0);
      cyc("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule